// File: doc/BRIEF.md
# Memory-Reference Operand Address Resolver

This block works out the final operand address of one instruction of a 12-bit, single-accumulator machine. A start pulse presents the instruction word and the program counter it was fetched from. The block splits the 3-bit opcode from the rest of the word. Memory-reference instructions build a page address from a 7-bit offset. Page zero sets the upper five address bits to zero, and the current page takes them from the program counter. When the indirect modifier is set, the block makes one read of a 4K-word synchronous memory at that page address, and the word it reads becomes the operand address.

I/O and operate instructions need no address. For these the block reports the class and, for I/O, the device and command fields, one cycle after start. The outputs are registered and change only in the cycle that done is high. Executing the instruction is left to the surrounding datapath.

Top module: `mref_addr_resolver`

## Requirements
- R1: After reset, done, mem_req, addr_out, cls, dev and cmd are all zero.
- R2: The opcode is instr[11:9]. Opcodes 0 to 5 report class 0 (memory reference), opcode 6 reports class 1 (I/O) and opcode 7 reports class 2 (operate).
- R3: For an I/O instruction, an operate instruction, or a memory-reference instruction with instr[8]=0, done is high for one cycle, in the cycle after start. No memory read takes place, even when bit 8 is set in an I/O or operate word.
- R4: The page address is {5'b0, instr[6:0]} when instr[7]=0 and {pc[11:7], instr[6:0]} when instr[7]=1. A direct memory reference returns this page address on addr_out.
- R5: A memory reference with instr[8]=1 makes exactly one read, at the page address. addr_out takes the word that was read, and done rises the cycle after mem_valid is seen with mem_req.
- R6: mem_req rises only in the cycle after start. Once raised, it stays high with mem_addr stable until mem_valid, and it drops in the cycle after mem_valid.
- R7: For an I/O instruction, dev = instr[8:3], cmd = instr[2:0] and addr_out = 0. For the other classes dev and cmd are 0, and operate instructions give addr_out = 0.
- R8: A start that arrives while an indirect read is outstanding is ignored. The outstanding instruction completes with its own result, and no second done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to resolve instr |
| instr | input | 12 | Instruction word |
| pc | input | 12 | Program counter of that instruction |
| mem_req | output | 1 | Memory read request, held until mem_valid |
| mem_addr | output | 12 | Memory read address |
| mem_valid | input | 1 | Read data present this cycle |
| mem_rdata | input | 12 | Read data word |
| done | output | 1 | Result valid pulse |
| addr_out | output | 12 | Resolved operand address |
| cls | output | 2 | Class: 0 memory reference, 1 I/O, 2 operate |
| dev | output | 6 | I/O device number |
| cmd | output | 3 | I/O command |

## Verification
The checker assumes that mem_valid is driven only while mem_req is high. It also assumes that mem_rdata is valid in the same cycle as mem_valid and that start lasts a single cycle. The bench memory model raises mem_valid only in answer to a held request. It drops mem_valid at once, and its data is a fixed arithmetic function of the address. Start is driven as a single-cycle pulse. The only start given while a read is outstanding is in the R8 case, which the properties allow for.

// File: rtl/mra_pkg.sv
package mra_pkg;
  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_IO  = 2'd1,
    CLS_OPR = 2'd2
  } cls_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_t;
endpackage

// File: rtl/mra_decode.sv
module mra_decode
  import mra_pkg::*;
#(
  parameter int W     = 12,
  parameter int OPC_W = 3,
  parameter int OFF_W = 7,
  parameter int CMD_W = 3
) (
  input  logic [W-1:0]           instr,
  input  logic [W-1:0]           pc,
  output cls_t                   cls,
  output logic                   indirect,
  output logic [W-1:0]           page_addr,
  output logic [W-OPC_W-CMD_W-1:0] dev,
  output logic [CMD_W-1:0]       cmd
);
  localparam int DEV_W   = W - OPC_W - CMD_W;
  localparam int IND_BIT = W - OPC_W - 1;
  localparam int PG_BIT  = W - OPC_W - 2;
  localparam logic [OPC_W-1:0] OPC_OPR = '1;
  localparam logic [OPC_W-1:0] OPC_IO  = OPC_OPR - 1'b1;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc = instr[W-1 -: OPC_W];
    if (opc == OPC_OPR)     cls = CLS_OPR;
    else if (opc == OPC_IO) cls = CLS_IO;
    else                    cls = CLS_MEM;
    indirect  = (cls == CLS_MEM) && instr[IND_BIT];
    page_addr = {(instr[PG_BIT] ? pc[W-1:OFF_W] : {(W-OFF_W){1'b0}}), instr[OFF_W-1:0]};
    dev       = instr[IND_BIT -: DEV_W];
    cmd       = instr[CMD_W-1:0];
  end
endmodule

// File: rtl/mra_seq.sv
module mra_seq
  import mra_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic indirect,
  input  logic mem_valid,
  output logic launch,
  output logic fin_now,
  output logic fin_rd,
  output logic mem_req
);
  st_t state;
  logic accept;

  always_comb begin
    accept  = start && (state == ST_IDLE);
    launch  = accept && indirect;
    fin_now = accept && !indirect;
    fin_rd  = (state == ST_WAIT) && mem_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mem_req <= 1'b0;
    end else if (launch) begin
      state   <= ST_WAIT;
      mem_req <= 1'b1;
    end else if (fin_rd) begin
      state   <= ST_IDLE;
      mem_req <= 1'b0;
    end
  end
endmodule

// File: rtl/mra_result.sv
module mra_result
  import mra_pkg::*;
#(
  parameter int W     = 12,
  parameter int DEV_W = 6,
  parameter int CMD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin_now,
  input  logic             fin_rd,
  input  cls_t             cls_in,
  input  logic [W-1:0]     page_addr,
  input  logic [W-1:0]     rd_word,
  input  logic [DEV_W-1:0] dev_in,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             done,
  output logic [W-1:0]     addr_out,
  output logic [1:0]       cls,
  output logic [DEV_W-1:0] dev,
  output logic [CMD_W-1:0] cmd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      addr_out <= '0;
      cls      <= CLS_MEM;
      dev      <= '0;
      cmd      <= '0;
    end else begin
      done <= fin_now || fin_rd;
      if (fin_rd) begin
        addr_out <= rd_word;
        cls      <= CLS_MEM;
        dev      <= '0;
        cmd      <= '0;
      end else if (fin_now) begin
        addr_out <= (cls_in == CLS_MEM) ? page_addr : '0;
        cls      <= cls_in;
        dev      <= (cls_in == CLS_IO) ? dev_in : '0;
        cmd      <= (cls_in == CLS_IO) ? cmd_in : '0;
      end
    end
  end
endmodule

// File: rtl/mref_addr_resolver.sv
module mref_addr_resolver
  import mra_pkg::*;
#(
  parameter int W     = 12,
  parameter int OPC_W = 3,
  parameter int OFF_W = 7,
  parameter int CMD_W = 3,
  localparam int DEV_W = W - OPC_W - CMD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     instr,
  input  logic [W-1:0]     pc,
  output logic             mem_req,
  output logic [W-1:0]     mem_addr,
  input  logic             mem_valid,
  input  logic [W-1:0]     mem_rdata,
  output logic             done,
  output logic [W-1:0]     addr_out,
  output logic [1:0]       cls,
  output logic [DEV_W-1:0] dev,
  output logic [CMD_W-1:0] cmd
);
  cls_t             d_cls;
  logic             d_ind;
  logic [W-1:0]     d_page;
  logic [DEV_W-1:0] d_dev;
  logic [CMD_W-1:0] d_cmd;
  logic             launch, fin_now, fin_rd;

  mra_decode #(.W(W), .OPC_W(OPC_W), .OFF_W(OFF_W), .CMD_W(CMD_W)) i_dec (
    .instr(instr), .pc(pc), .cls(d_cls), .indirect(d_ind),
    .page_addr(d_page), .dev(d_dev), .cmd(d_cmd)
  );

  mra_seq i_seq (
    .clk(clk), .rst(rst), .start(start), .indirect(d_ind), .mem_valid(mem_valid),
    .launch(launch), .fin_now(fin_now), .fin_rd(fin_rd), .mem_req(mem_req)
  );

  always_ff @(posedge clk) begin
    if (rst)         mem_addr <= '0;
    else if (launch) mem_addr <= d_page;
  end

  mra_result #(.W(W), .DEV_W(DEV_W), .CMD_W(CMD_W)) i_res (
    .clk(clk), .rst(rst), .fin_now(fin_now), .fin_rd(fin_rd), .cls_in(d_cls),
    .page_addr(d_page), .rd_word(mem_rdata), .dev_in(d_dev), .cmd_in(d_cmd),
    .done(done), .addr_out(addr_out), .cls(cls), .dev(dev), .cmd(cmd)
  );
endmodule

// File: rtl/mra_checker.sv
module mra_checker #(
  parameter int W     = 12,
  parameter int OPC_W = 3,
  parameter int DEV_W = 6,
  parameter int CMD_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [W-1:0]     instr,
  input logic             mem_req,
  input logic [W-1:0]     mem_addr,
  input logic             mem_valid,
  input logic [W-1:0]     mem_rdata,
  input logic             done,
  input logic [W-1:0]     addr_out,
  input logic [1:0]       cls,
  input logic [DEV_W-1:0] dev,
  input logic [CMD_W-1:0] cmd
);
  localparam logic [OPC_W-1:0] OPC_LAST_MEM = {OPC_W{1'b1}} - 2'd2;
  logic start_ind;
  assign start_ind = (instr[W-1 -: OPC_W] <= OPC_LAST_MEM) && instr[W-OPC_W-1];

  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(start)); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R6
  AST_IND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_valid) |=> (done && !mem_req && addr_out == $past(mem_rdata) && cls == 2'd0)); // R5
  AST_FAST_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && !start_ind) |=> (done && !mem_req)); // R3
  AST_OPR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && cls == 2'd2) |-> (addr_out == '0 && dev == '0 && cmd == '0)); // R7
  AST_MEM_NO_IO: assert property (@(posedge clk) disable iff (rst)
    (done && cls == 2'd0) |-> (dev == '0 && cmd == '0)); // R7
  AST_CLS_RANGE: assert property (@(posedge clk) disable iff (rst)
    cls != 2'd3); // R2
endmodule

bind mref_addr_resolver mra_checker #(.W(W), .OPC_W(OPC_W), .DEV_W(DEV_W), .CMD_W(CMD_W)) i_chk (
  .clk(clk), .rst(rst), .start(start), .instr(instr), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done),
  .addr_out(addr_out), .cls(cls), .dev(dev), .cmd(cmd)
);

// File: tb/test_mref_addr_resolver.sv
module test_mref_addr_resolver;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [11:0] instr = '0, pc = '0;
  logic mem_req, mem_valid;
  logic [11:0] mem_addr, mem_rdata;
  logic done;
  logic [11:0] addr_out;
  logic [1:0] cls;
  logic [5:0] dev;
  logic [2:0] cmd;
  int checks = 0, fails = 0, cyc = 0, rd_cnt = 0;
  logic [11:0] rd_last = '0;

  always #2.5 clk = ~clk;

  mref_addr_resolver i_mref_addr_resolver (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc(pc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .done(done), .addr_out(addr_out), .cls(cls), .dev(dev), .cmd(cmd)
  );

  function automatic logic [11:0] memw(logic [11:0] a);
    return 12'((a * 12'd37) + 12'd5) ^ 12'h5A3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_valid <= mem_req && !mem_valid;
      mem_rdata <= memw(mem_addr);
      if (mem_req && mem_valid) begin
        rd_cnt  = rd_cnt + 1;
        rd_last = mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_one(input logic [11:0] i, input logic [11:0] p);
    logic [2:0] opc;
    logic [11:0] pa, ea;
    logic ind;
    int n, exp_cls, exp_lat;
    opc = i[11:9];
    pa  = {(i[7] ? p[11:7] : 5'd0), i[6:0]};
    ind = (opc < 3'd6) && i[8];
    exp_cls = (opc == 3'd7) ? 2 : (opc == 3'd6) ? 1 : 0;
    ea  = (opc >= 3'd6) ? 12'd0 : (ind ? memw(pa) : pa);
    exp_lat = ind ? 3 : 1;
    rd_cnt = 0;
    @(negedge clk);
    instr = i; pc = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp_lat, ind ? "R5 latency" : "R3 latency", n, exp_lat);
    chk(int'(cls) == exp_cls, "R2 class", cls, exp_cls);
    chk(addr_out == ea, ind ? "R5 address" : "R4 address", addr_out, ea);
    chk(rd_cnt == (ind ? 1 : 0), "R3 read count", rd_cnt, ind ? 1 : 0);
    if (ind) chk(rd_last == pa, "R5 read address", rd_last, pa);
    chk(dev == ((opc == 3'd6) ? i[8:3] : 6'd0), "R7 dev", dev, (opc == 3'd6) ? i[8:3] : 6'd0);
    chk(cmd == ((opc == 3'd6) ? i[2:0] : 3'd0), "R7 cmd", cmd, (opc == 3'd6) ? i[2:0] : 3'd0);
    @(negedge clk);
    chk(!done && !mem_req, "R6 quiet after done", {done, mem_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !mem_req && addr_out == 0 && cls == 0 && dev == 0 && cmd == 0,
        "R1 reset state", {done, mem_req, addr_out}, 0);

    for (int k = 0; k < 4096; k++) begin
      run_one(12'(k), 12'hF80);
      run_one(12'(k), 12'h2B5);
    end

    // R8: second start while indirect read is outstanding
    @(negedge clk);
    instr = 12'b010_1_1_0010011; pc = 12'h6A0; start = 1'b1;
    @(negedge clk);
    instr = 12'b001_0_0_1111111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R8 ignored start gives no done", done, 0);
    @(negedge clk);
    chk(done && addr_out == memw(12'h693), "R8 first result kept", addr_out, memw(12'h693));
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(!done && !mem_req, "R8 no second done", {done, mem_req}, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule